// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block turns a programmed mode word and a stream of column commands into the column address sequence of a double-data-rate burst. A write of the 12-bit mode word sets three things: the burst length (2, 4 or 8 beats), the beat ordering (wrap-around sequential or XOR interleaved) and the CAS latency. Each read or write command carries a 9-bit start column. From the next clock the block presents two column addresses per clock, an even beat and an odd beat, until the burst is complete.

Only the low log2(BL) column bits move during a burst. The upper bits keep the value of the start column. A new column command given during a burst cuts the burst short and starts again from the new column. A stop input, driven by a burst-terminate or precharge command, ends the sequence at once. A mode word with a reserved code is refused: an error flag rises and the previous legal setting stays in force. A running burst keeps the length and ordering it captured when it started.

Top module: `ddr_burst_colgen`

## Requirements
- R1: Mode bits [2:0] give the burst length: 001 gives 2, 010 gives 4 and 011 gives 8, reported on `cfg_bl` as the beat count. Every other code is reserved.
- R2: Mode bit [3] gives the ordering: 0 is sequential and 1 is interleaved, reported on `cfg_ilv`.
- R3: Mode bits [6:4] give the CAS latency in half clocks on `cfg_cl_half`: 010 gives 4, 011 gives 6 and 110 gives 5. Every other code is reserved.
- R4: In the cycle after a mode write, `cfg_err` is 1 if the burst-length code or the latency code is reserved, and 0 otherwise. On a reserved write, `cfg_bl`, `cfg_ilv` and `cfg_cl_half` keep their old values. When no mode write occurs, `cfg_err` holds its value.
- R5: In the cycle after a column command, `pair_valid` rises. The block then shows BL/2 pairs on consecutive cycles. `pair_last` is 1 only with the final pair, and `pair_valid` is 0 in the cycle after it unless a new command arrives.
- R6: In sequential mode, beat b of a burst of length BL that starts at column s is base + ((s mod BL) + b) mod BL, where base = s − (s mod BL). Pair k shows beat 2k on `col_even` and beat 2k+1 on `col_odd`.
- R7: In interleaved mode, beat b is base + ((s mod BL) XOR b).
- R8: Within a burst, column bits [8:3] of both lanes equal those of the start column.
- R9: A column command given during a burst restarts the sequence from its own column in the following cycle. When a stop arrives in the same cycle, the command wins.
- R10: A stop input without a column command makes `pair_valid` 0 from the next cycle. A stop given while idle has no effect.
- R11: A legal mode write with bit [8] set produces a one-cycle pulse on `dll_rst` in the following cycle. Any other write gives no pulse.
- R12: After reset, the setting is BL=2, sequential, latency 4 half clocks. `cfg_err`, `pair_valid`, `pair_last` and `dll_rst` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load `mode_word` this cycle |
| mode_word | input | 12 | Mode word with length, ordering, latency and DLL-reset fields |
| cmd_start | input | 1 | Read or write column command |
| start_col | input | 9 | Start column of the command |
| cmd_stop | input | 1 | Burst terminate or precharge: end the sequence |
| col_even | output | 9 | Column of the even beat of the current pair |
| col_odd | output | 9 | Column of the odd beat of the current pair |
| pair_valid | output | 1 | A pair of beats is presented |
| pair_last | output | 1 | The presented pair is the final pair of the burst |
| cfg_bl | output | 4 | Active burst length in beats |
| cfg_ilv | output | 1 | Active ordering, 1 = interleaved |
| cfg_cl_half | output | 3 | Active CAS latency in half clocks |
| cfg_err | output | 1 | The last mode write carried a reserved code |
| dll_rst | output | 1 | One-cycle DLL reset request |

## Verification
The bench uses the default 9-bit column and 12-bit mode word. At these sizes the sweeps are exhaustive. All 4096 mode words are written in turn, which covers every reserved and legal pairing of the length and latency fields together with the DLL-reset bit. For each of the six legal length and ordering settings, a burst is run from each of the 512 start columns, so every alignment of the wrap and XOR patterns is checked. Directed sequences then exercise a restart during a burst, a stop during a burst and while idle, and a command and a stop given in the same cycle.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  localparam int MAX_BL_LOG = 3;
  localparam int PAIR_W     = MAX_BL_LOG - 1;

  typedef struct packed {
    logic [1:0] bl_log;
    logic       ilv;
    logic [2:0] cl_half;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{bl_log: 2'd1, ilv: 1'b0, cl_half: 3'd4};

  // Burst-length field to log2(BL); 0 marks a reserved code
  function automatic logic [1:0] bl_log_of(input logic [2:0] code);
    case (code)
      3'b001:  return 2'd1;
      3'b010:  return 2'd2;
      3'b011:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // Latency field to half clocks; 0 marks a reserved code
  function automatic logic [2:0] cl_half_of(input logic [2:0] code);
    case (code)
      3'b010:  return 3'd4;
      3'b011:  return 3'd6;
      3'b110:  return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  // Index of the final pair for a given log2(BL)
  function automatic logic [PAIR_W-1:0] final_pair_of(input logic [1:0] bl_log);
    case (bl_log)
      2'd2:    return PAIR_W'(1);
      2'd3:    return PAIR_W'(3);
      default: return PAIR_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import colgen_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  output burst_cfg_t        cfg,
  output logic              cfg_err,
  output logic              dll_rst
);

  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int DLL_BIT = 8;

  logic [1:0] new_bl_log;
  logic [2:0] new_cl_half;
  logic       wr_legal;
  logic       wr_rsvd;
  logic       unused_mode_bits;

  assign new_bl_log  = bl_log_of(mode_word[BL_LSB +: 3]);
  assign new_cl_half = cl_half_of(mode_word[CL_LSB +: 3]);
  assign wr_legal    = mode_wr && (new_bl_log != 2'd0) && (new_cl_half != 3'd0);
  assign wr_rsvd     = mode_wr && !wr_legal;
  assign unused_mode_bits = ^{mode_word[MODE_W-1:DLL_BIT+1], mode_word[7]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= CFG_RESET;
      cfg_err <= 1'b0;
      dll_rst <= 1'b0;
    end else begin
      dll_rst <= wr_legal && mode_word[DLL_BIT];
      if (mode_wr) cfg_err <= wr_rsvd;
      if (wr_legal) begin
        cfg.bl_log  <= new_bl_log;
        cfg.ilv     <= mode_word[BT_BIT];
        cfg.cl_half <= new_cl_half;
      end
    end
  end

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(cfg_err)); // R4
  AST_RSVD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rsvd |=> $stable(cfg) && cfg_err); // R4
  AST_DLL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dll_rst |-> $past(mode_wr)); // R11
  AST_LEGAL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_legal |=> !cfg_err); // R4

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              cmd_stop,
  input  burst_cfg_t        cfg,
  output logic              active,
  output logic [PAIR_W-1:0] pair_idx,
  output logic [COL_W-1:0]  base_col,
  output logic [1:0]        run_bl_log,
  output logic              run_ilv,
  output logic              last_pair
);

  logic [PAIR_W-1:0] final_idx;
  logic              burst_cut;
  logic              burst_stop;
  logic              burst_done;

  assign final_idx  = final_pair_of(run_bl_log);
  assign last_pair  = active && (pair_idx == final_idx);
  assign burst_cut  = cmd_start && active;
  assign burst_stop = cmd_stop && !cmd_start && active;
  assign burst_done = last_pair && !cmd_start && !cmd_stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      pair_idx   <= '0;
      base_col   <= '0;
      run_bl_log <= 2'd1;
      run_ilv    <= 1'b0;
    end else if (cmd_start) begin
      active     <= 1'b1;
      pair_idx   <= '0;
      base_col   <= start_col;
      run_bl_log <= cfg.bl_log;
      run_ilv    <= cfg.ilv;
    end else if (cmd_stop) begin
      active     <= 1'b0;
    end else if (active) begin
      if (last_pair) active <= 1'b0;
      else           pair_idx <= pair_idx + PAIR_W'(1);
    end
  end

  AST_LAST_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    last_pair |-> active); // R5
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_start) |=> !active); // R10
  AST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !active); // R5
  AST_CUT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cut |=> active && (pair_idx == '0)); // R9
  AST_STOP_MID: assert property (@(posedge clk) disable iff (!rst_n)
    burst_stop |=> !last_pair); // R10

endmodule

// File: rtl/colgen_addr.sv
module colgen_addr
  import colgen_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LANE  = 0
) (
  input  logic [COL_W-1:0]  base_col,
  input  logic [PAIR_W-1:0] pair_idx,
  input  logic [1:0]        bl_log,
  input  logic              ilv,
  output logic [COL_W-1:0]  col
);

  localparam int PAD_W = COL_W - MAX_BL_LOG;

  function automatic logic [COL_W-1:0] beat_col(
    input logic [COL_W-1:0]      start,
    input logic [MAX_BL_LOG-1:0] beat,
    input logic [1:0]            lg,
    input logic                  interleave
  );
    logic [COL_W-1:0] low_mask;
    logic [COL_W-1:0] wide_beat;
    logic [COL_W-1:0] moved;
    low_mask  = ~({COL_W{1'b1}} << lg);
    wide_beat = {{PAD_W{1'b0}}, beat};
    moved     = interleave ? (start ^ wide_beat) : (start + wide_beat);
    return (start & ~low_mask) | (moved & low_mask);
  endfunction

  logic [MAX_BL_LOG-1:0] beat_num;

  assign beat_num = {pair_idx, 1'(LANE)};
  assign col      = beat_col(base_col, beat_num, bl_log, ilv);

endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [MODE_W-1:0] mode_word,
  input  logic              cmd_start,
  input  logic [COL_W-1:0]  start_col,
  input  logic              cmd_stop,
  output logic [COL_W-1:0]  col_even,
  output logic [COL_W-1:0]  col_odd,
  output logic              pair_valid,
  output logic              pair_last,
  output logic [3:0]        cfg_bl,
  output logic              cfg_ilv,
  output logic [2:0]        cfg_cl_half,
  output logic              cfg_err,
  output logic              dll_rst
);

  localparam int LANES = 2;

  burst_cfg_t        cfg;
  logic              active;
  logic [PAIR_W-1:0] pair_idx;
  logic [COL_W-1:0]  base_col;
  logic [1:0]        run_bl_log;
  logic              run_ilv;
  logic              last_pair;
  logic [COL_W-1:0]  lane_col [LANES];

  colgen_mode_dec #(.MODE_W(MODE_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_word (mode_word),
    .cfg       (cfg),
    .cfg_err   (cfg_err),
    .dll_rst   (dll_rst)
  );

  colgen_seq #(.COL_W(COL_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_start  (cmd_start),
    .start_col  (start_col),
    .cmd_stop   (cmd_stop),
    .cfg        (cfg),
    .active     (active),
    .pair_idx   (pair_idx),
    .base_col   (base_col),
    .run_bl_log (run_bl_log),
    .run_ilv    (run_ilv),
    .last_pair  (last_pair)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    colgen_addr #(.COL_W(COL_W), .LANE(g)) u_addr (
      .base_col (base_col),
      .pair_idx (pair_idx),
      .bl_log   (run_bl_log),
      .ilv      (run_ilv),
      .col      (lane_col[g])
    );
  end

  assign col_even    = lane_col[0];
  assign col_odd     = lane_col[1];
  assign pair_valid  = active;
  assign pair_last   = last_pair;
  assign cfg_bl      = 4'd1 << cfg.bl_log;
  assign cfg_ilv     = cfg.ilv;
  assign cfg_cl_half = cfg.cl_half;

  AST_FIRST_COL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> pair_valid && (col_even == $past(start_col))); // R9
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (col_even[COL_W-1:MAX_BL_LOG] == col_odd[COL_W-1:MAX_BL_LOG])); // R8
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last |-> pair_valid); // R5
  AST_LANES_DIFFER: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (col_even != col_odd)); // R6

endmodule

// File: tb/ddr_burst_colgen_bench.sv
`timescale 1ns/1ps
module ddr_burst_colgen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0;
  logic [11:0] mode_word = '0;
  logic        cmd_start = 1'b0;
  logic [8:0]  start_col = '0;
  logic        cmd_stop = 1'b0;
  logic [8:0]  col_even, col_odd;
  logic        pair_valid, pair_last;
  logic [3:0]  cfg_bl;
  logic        cfg_ilv;
  logic [2:0]  cfg_cl_half;
  logic        cfg_err, dll_rst;

  int vectors = 0;
  int miscompares = 0;
  int m_bl = 2;
  int m_ilv = 0;
  int m_clh = 4;
  int m_err = 0;

  always #2 clk = ~clk;

  ddr_burst_colgen u_ddr_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_word(mode_word),
    .cmd_start(cmd_start), .start_col(start_col), .cmd_stop(cmd_stop),
    .col_even(col_even), .col_odd(col_odd), .pair_valid(pair_valid),
    .pair_last(pair_last), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv),
    .cfg_cl_half(cfg_cl_half), .cfg_err(cfg_err), .dll_rst(dll_rst)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(int s, int b, int bl, int ilv);
    int off = s % bl;
    int base = s - off;
    if (ilv != 0) return base + (off ^ b);
    return base + ((off + b) % bl);
  endfunction

  function automatic int bl_of(int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int clh_of(int code);
    case (code)
      2: return 4;
      3: return 6;
      6: return 5;
      default: return 0;
    endcase
  endfunction

  task automatic write_mode(input int w);
    int bl = bl_of(w & 7);
    int clh = clh_of((w >> 4) & 7);
    int legal = (bl != 0 && clh != 0) ? 1 : 0;
    @(negedge clk);
    mode_wr = 1'b1;
    mode_word = 12'(w);
    @(negedge clk);
    mode_wr = 1'b0;
    m_err = legal ? 0 : 1;
    if (legal != 0) begin
      m_bl = bl;
      m_ilv = (w >> 3) & 1;
      m_clh = clh;
    end
    chk("R4 cfg_err", int'(cfg_err), m_err);
    chk("R1 cfg_bl", int'(cfg_bl), m_bl);
    chk("R2 cfg_ilv", int'(cfg_ilv), m_ilv);
    chk("R3 cfg_cl_half", int'(cfg_cl_half), m_clh);
    chk("R11 dll_rst", int'(dll_rst), legal & ((w >> 8) & 1));
  endtask

  task automatic check_pair(input string req, input int s, input int k, input int npairs);
    chk({req, " valid"}, int'(pair_valid), 1);
    chk({req, " even"}, int'(col_even), exp_col(s, 2 * k, m_bl, m_ilv));
    chk({req, " odd"}, int'(col_odd), exp_col(s, 2 * k + 1, m_bl, m_ilv));
    chk({req, " last"}, int'(pair_last), (k == npairs - 1) ? 1 : 0);
  endtask

  task automatic run_burst(input int s);
    string req;
    req = (m_ilv != 0) ? "R7" : "R6";
    @(negedge clk);
    cmd_start = 1'b1;
    start_col = 9'(s);
    for (int k = 0; k < m_bl / 2; k++) begin
      @(negedge clk);
      cmd_start = 1'b0;
      check_pair(req, s, k, m_bl / 2);
    end
    @(negedge clk);
    chk("R5 valid after last", int'(pair_valid), 0);
  endtask

  initial begin
    #800000;
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 cfg_bl", int'(cfg_bl), 2);
    chk("R12 cfg_ilv", int'(cfg_ilv), 0);
    chk("R12 cfg_cl_half", int'(cfg_cl_half), 4);
    chk("R12 cfg_err", int'(cfg_err), 0);
    chk("R12 pair_valid", int'(pair_valid), 0);
    chk("R12 pair_last", int'(pair_last), 0);
    chk("R12 dll_rst", int'(dll_rst), 0);

    // R1 R2 R3 R4 R11: every mode word
    for (int w = 0; w < 4096; w++) write_mode(w);
    @(negedge clk);
    chk("R11 dll pulse ends", int'(dll_rst), 0);
    chk("R4 err holds", int'(cfg_err), m_err);

    // R6 R7 R8: all starts for each legal length and ordering
    for (int c = 1; c <= 3; c++) begin
      for (int t = 0; t < 2; t++) begin
        write_mode(32'h020 | (t << 3) | c);
        for (int s = 0; s < 512; s++) run_burst(s);
      end
    end

    // R9 restart during a burst, BL=8 sequential
    write_mode(12'h023);
    @(negedge clk);
    cmd_start = 1'b1; start_col = 9'd5;
    @(negedge clk);
    cmd_start = 1'b0;
    check_pair("R9 pre", 5, 0, 4);
    @(negedge clk);
    check_pair("R9 pre", 5, 1, 4);
    cmd_start = 1'b1; start_col = 9'h1A3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cmd_start = 1'b0;
      check_pair("R9 restart", 'h1A3, k, 4);
    end
    @(negedge clk);
    chk("R9 end", int'(pair_valid), 0);

    // R10 stop during a burst, BL=8 interleaved
    write_mode(12'h02B);
    @(negedge clk);
    cmd_start = 1'b1; start_col = 9'h00D;
    @(negedge clk);
    cmd_start = 1'b0;
    check_pair("R10 first", 'h00D, 0, 4);
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    chk("R10 stopped", int'(pair_valid), 0);
    chk("R10 stopped last", int'(pair_last), 0);
    @(negedge clk);
    chk("R10 stays idle", int'(pair_valid), 0);

    // R10 stop while idle has no effect
    cmd_stop = 1'b1;
    @(negedge clk);
    cmd_stop = 1'b0;
    chk("R10 idle stop", int'(pair_valid), 0);
    chk("R10 idle stop cfg", int'(cfg_bl), 8);

    // R9 command and stop in the same cycle: command wins
    @(negedge clk);
    cmd_start = 1'b1; cmd_stop = 1'b1; start_col = 9'h0F2;
    @(negedge clk);
    cmd_start = 1'b0; cmd_stop = 1'b0;
    check_pair("R9 start beats stop", 'h0F2, 0, 4);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      check_pair("R9 start beats stop", 'h0F2, k, 4);
    end
    @(negedge clk);
    chk("R5 end", int'(pair_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule